// File: doc/BRIEF.md
# DMA Completion Interrupt Status and Mask Register

This block gathers the end-of-transfer events of up to sixteen DMA channels into one 32-bit register and turns them into a single interrupt request. The low half of the register holds one sticky status flag per channel. The high half holds one enable bit per channel. Each channel engine sends a one-cycle completion pulse on its own line, and that pulse sets the channel's flag.

Software controls the register through one write port and reads it through one read port. A write clears the status flags where the low half of the data has ones. The same write inverts the enable bits where the high half of the data has ones. Zeros in the data leave the matching bits as they are, so software can acknowledge events and adjust enables without first reading the register.

The interrupt request is a registered level. It reflects the register contents of the previous cycle. Only a fixed, sparse set of bit positions can raise it:
- status flags in the pattern 0xE3FF;
- enable bits in the pattern 0x63FF, counted within the high half.

Top module: `dmairq_status_reg`

## Requirements
- R1: A synchronous active-high reset clears all 32 bits of `rd_data` and drives `irq` low.
- R2: A one-cycle pulse on `done_pulse[n]` sets status bit n (`rd_data[n]`) at the next clock edge. The bit stays set until software clears it.
- R3: When `wr_en` is high, each one in `wr_data[15:0]` clears the matching status bit. Each zero in `wr_data[15:0]` leaves its status bit unchanged.
- R4: When `wr_en` is high, each one in `wr_data[31:16]` inverts the matching enable bit (`rd_data[31:16]`). Each zero leaves its enable bit unchanged. With `wr_en` low, the enable bits hold their value.
- R5: If a completion pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq` is high in the cycle after the register holds a nonzero value of (status AND 0xE3FF AND enable AND 0x63FF). Otherwise `irq` is low in that cycle.
- R7: Status bits 10, 11, 12 and 15 can be set and read back, and enable bits 10, 11, 12 and 15 can be toggled and read back. These bits never cause `irq`, even when the matching status and enable bits are both set.
- R8: `rd_data` always shows the current register: enable bits in [31:16] and status bits in [15:0].
- R9: A completion pulse on one bit and a clear of a different bit in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_pulse | input | 16 | Per-channel completion pulses, bit n for channel n |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data: [31:16] toggles enables, [15:0] clears status |
| rd_data | output | 32 | Current register contents |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench walks through several stimulus patterns and checks what each one shows:
- **Lone completion pulses** show that flags are sticky.
- **Repeated writes of the same enable pattern** show toggling, as opposed to loading.
- **Writes with mixed ones and zeros** show that zero bits are left alone.
- **A pulse and a clear on the same bit** show which one has priority. **A pulse and a clear on different bits** show that both updates happen independently.
- **Enabling the excluded positions (10 to 12 and 15)** shows that the sparse compare is used, not a plain AND of the two halves. **Enabling bits 13 and 14** shows that those positions can still raise the request.
- **Reset in the middle of a run** shows that a loaded register returns to zero.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    // Width of one register half: one bit per DMA channel.
    localparam int HALF_W = 16;
    localparam int REG_W  = 2 * HALF_W;

    // Default positions that take part in the interrupt compare.
    localparam logic [HALF_W-1:0] DEF_STAT_PAT = 16'hE3FF;
    localparam logic [HALF_W-1:0] DEF_MASK_PAT = 16'h63FF;

    typedef logic [HALF_W-1:0] half_t;

    // Architectural register view.
    typedef struct packed {
        half_t enable;
        half_t status;
    } irq_reg_t;

    // Decoded CPU write for one cycle.
    typedef struct packed {
        half_t clr;
        half_t tgl;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_write(input logic en, input logic [REG_W-1:0] data);
        wr_cmd_t c;
        c.clr = en ? data[HALF_W-1:0]     : '0;
        c.tgl = en ? data[REG_W-1:HALF_W] : '0;
        return c;
    endfunction

    function automatic logic irq_hit(input half_t st, input half_t en,
                                     input half_t st_pat, input half_t en_pat);
        return |((st & st_pat) & (en & en_pat));
    endfunction

endpackage

// File: rtl/dmairq_status_bank.sv
module dmairq_status_bank
    import dmairq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  half_t set_i,
    input  half_t clr_i,
    output half_t status_o
);

    half_t status_q;

    generate
        for (genvar b = 0; b < HALF_W; b++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)
                    status_q[b] <= 1'b0;
                else if (set_i[b])
                    status_q[b] <= 1'b1;   // set has priority over clear
                else if (clr_i[b])
                    status_q[b] <= 1'b0;
            end
        end
    endgenerate

    assign status_o = status_q;

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i))); // R2

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_i)) == '0)); // R2

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_i != '0) |=> ((status_q & $past(clr_i & ~set_i)) == '0)); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ((set_i & clr_i) != '0) |=> ((status_q & $past(set_i & clr_i)) == $past(set_i & clr_i))); // R5

endmodule

// File: rtl/dmairq_mask_bank.sv
module dmairq_mask_bank
    import dmairq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  half_t tgl_i,
    output half_t enable_o
);

    half_t enable_q;

    always_ff @(posedge clk) begin
        if (rst)
            enable_q <= '0;
        else
            enable_q <= enable_q ^ tgl_i;
    end

    assign enable_o = enable_q;

    AST_MASK_INVERTS: assert property (@(posedge clk) disable iff (rst)
        (tgl_i != '0) |=> ((enable_q & $past(tgl_i)) == (~$past(enable_q) & $past(tgl_i)))); // R4

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((enable_q & ~$past(tgl_i)) == ($past(enable_q) & ~$past(tgl_i)))); // R4

endmodule

// File: rtl/dmairq_irq_eval.sv
module dmairq_irq_eval
    import dmairq_pkg::*;
#(
    parameter half_t STAT_PAT = DEF_STAT_PAT,
    parameter half_t MASK_PAT = DEF_MASK_PAT
) (
    input  logic  clk,
    input  logic  rst,
    input  half_t status_i,
    input  half_t enable_i,
    output logic  irq_o
);

    localparam half_t LIVE_BITS = STAT_PAT & MASK_PAT;

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= irq_hit(status_i, enable_i, STAT_PAT, MASK_PAT);
    end

    assign irq_o = irq_q;

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(status_i & enable_i & LIVE_BITS) != '0)); // R6

    AST_IRQ_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        ((status_i & LIVE_BITS) == '0) |=> !irq_q); // R7

endmodule

// File: rtl/dmairq_status_reg.sv
module dmairq_status_reg
    import dmairq_pkg::*;
#(
    parameter logic [HALF_W-1:0] STAT_PAT = DEF_STAT_PAT,
    parameter logic [HALF_W-1:0] MASK_PAT = DEF_MASK_PAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] done_pulse,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq
);

    wr_cmd_t  cmd;
    irq_reg_t regv;

    assign cmd = decode_write(wr_en, wr_data);

    dmairq_status_bank u_status (
        .clk      (clk),
        .rst      (rst),
        .set_i    (done_pulse),
        .clr_i    (cmd.clr),
        .status_o (regv.status)
    );

    dmairq_mask_bank u_mask (
        .clk      (clk),
        .rst      (rst),
        .tgl_i    (cmd.tgl),
        .enable_o (regv.enable)
    );

    dmairq_irq_eval #(
        .STAT_PAT (STAT_PAT),
        .MASK_PAT (MASK_PAT)
    ) u_eval (
        .clk      (clk),
        .rst      (rst),
        .status_i (regv.status),
        .enable_i (regv.enable),
        .irq_o    (irq)
    );

    assign rd_data = regv;

    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && !irq)); // R1

    AST_PULSE_AND_CLEAR_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ((done_pulse & wr_data[HALF_W-1:0]) == '0) && (done_pulse != '0)
                && (wr_data[HALF_W-1:0] != '0))
        |=> ((rd_data[HALF_W-1:0] & $past(wr_data[HALF_W-1:0])) == '0)); // R9

endmodule

// File: tb/dmairq_status_reg_tb_top.sv
module dmairq_status_reg_tb_top;

    localparam logic [15:0] SPAT = 16'hE3FF;
    localparam logic [15:0] MPAT = 16'h63FF;

    typedef struct {
        logic [31:0] reg_v;
        logic        irq_v;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] done_pulse;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    exp_t        sb_q[$];
    logic [31:0] model;

    always #5 clk = ~clk;

    dmairq_status_reg dut_i (
        .clk(clk), .rst(rst), .done_pulse(done_pulse),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic model_irq(input logic [31:0] r);
        return |((r[15:0] & SPAT) & (r[31:16] & MPAT));
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected result pushed to the scoreboard.
    task automatic step(input logic [15:0] dp, input logic we, input logic [31:0] wd, input string tag);
        exp_t e;
        logic [31:0] nxt;
        @(negedge clk);
        done_pulse = dp;
        wr_en      = we;
        wr_data    = wd;
        nxt[31:16] = model[31:16] ^ (we ? wd[31:16] : 16'h0);
        nxt[15:0]  = (model[15:0] & ~(we ? wd[15:0] : 16'h0)) | dp;
        e.irq_v = model_irq(model);
        e.reg_v = nxt;
        e.tag   = tag;
        model   = nxt;
        sb_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(16'h0, 1'b0, 32'h0, tag);
    endtask

    task automatic drain;
        @(negedge clk);
        done_pulse = '0; wr_en = 1'b0; wr_data = '0;
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_reset(input string tag);
        drain();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        check(tag, "rd_data after reset", rd_data, 32'h0);
        check(tag, "irq after reset", {31'h0, irq}, 32'h0);
    endtask

    // Monitor: compares design output against the scoreboard after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() != 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, "rd_data", rd_data, e.reg_v);
                check(e.tag, "irq", {31'h0, irq}, {31'h0, e.irq_v});
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; done_pulse = '0; wr_en = 1'b0; wr_data = '0; model = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "rd_data at start", rd_data, 32'h0);
        check("R1", "irq at start", {31'h0, irq}, 32'h0);

        // R2: sticky completion flag
        step(16'h0008, 1'b0, 32'h0, "R2");
        idle("R2");
        idle("R8");
        // R4: toggle enable bit 3 on, then R6 request follows one cycle later
        step(16'h0, 1'b1, 32'h0008_0000, "R4");
        idle("R6");
        idle("R6");
        // R4: same pattern again toggles it off
        step(16'h0, 1'b1, 32'h0008_0000, "R4");
        idle("R6");
        // R3: zeros leave bits, ones clear
        step(16'h0021, 1'b0, 32'h0, "R2");
        step(16'h0, 1'b1, 32'h0000_0001, "R3");
        step(16'h0, 1'b1, 32'h0000_0000, "R3");
        // R5: pulse and clear on same bit
        step(16'h0020, 1'b1, 32'h0000_0020, "R5");
        idle("R5");
        // R9: pulse on bit 0, clear bit 5
        step(16'h0001, 1'b1, 32'h0000_0020, "R9");
        step(16'h0, 1'b1, 32'h0000_0001, "R9");
        // R7: excluded positions set and enabled, no request
        step(16'h9C00, 1'b1, 32'h9C00_0000, "R7");
        idle("R7");
        idle("R7");
        // R6: bits 13 and 14 do raise the request
        step(16'h6000, 1'b1, 32'h2000_0000, "R6");
        idle("R6");
        idle("R6");
        step(16'h0, 1'b1, 32'h0000_2000, "R6");
        idle("R6");
        step(16'h0, 1'b1, 32'h4000_0000, "R6");
        idle("R6");
        idle("R6");
        // R4: writing zeros keeps enables; idle keeps them
        step(16'h0, 1'b1, 32'h0000_0000, "R4");
        idle("R4");
        // R1: reset from a loaded state
        step(16'hFFFF, 1'b1, 32'hFFFF_0000, "R8");
        idle("R8");
        do_reset("R1");
        idle("R1");
        drain();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule